// File: doc/BRIEF.md
# Link Command Executor with One-Shot Arming

This block sits behind one or more link header interpreters and carries out the simple control commands they decode. Each interpreter offers one command at a time on its own valid/ready request port. A fixed-priority arbiter picks one request per clock, and the chosen command is executed at that clock edge. The block drives a CPU reset level, a bank of user flag levels and one reset pulse line per link.

Commands that can disturb the system are safety-critical: asserting CPU reset, resetting one link and resetting all links. They run only while an arming register is set. An arm command sets that register, and each critical command that runs clears it again, so every critical action needs its own fresh arm. A critical request that arrives while the block is not armed is still accepted, but it does nothing and raises a one-cycle reject pulse that names the requesting channel. The interpreters can watch `armed_o` to tell ahead of time whether a critical request would be allowed.

Back-pressure rules: a requester raises valid and holds its opcode and argument stable until it sees ready high at a rising clock edge. Ready is never raised for a channel whose valid is low. Each command is consumed exactly once, whether it is executed, refused or has no effect.

Top module: `ctl_cmd_exec`

## Requirements
- R1: While reset is held, and directly after it, cpu_rst_o, flag_o, link_rst_o, armed_o and reject_o are all 0.
- R2: In any cycle, req_ready_o is high only for the lowest-index channel whose req_valid_i is high, so at most one bit is set. A command is consumed at the rising edge where its valid and ready are both high.
- R3: Opcode 1 (ARM) sets armed_o from the next cycle on. armed_o stays set while the only commands executed are non-critical ones.
- R4: Opcode 2 (CPU_HOLD) is critical: when it executes it sets cpu_rst_o from the next cycle on. Opcode 3 (CPU_RELEASE) is not critical: it clears cpu_rst_o whether or not the block is armed, and it leaves the arm state as it is.
- R5: Opcode 4 (FLAG_SET) sets flag_o[arg] and opcode 5 (FLAG_CLR) clears it. All other flag bits keep their values. Neither opcode needs the arm state or changes it.
- R6: Opcode 6 (LINK_RST) is critical. When armed and arg < NUM_LINKS, it drives link_rst_o[arg] high for exactly the next cycle, and all other link lines stay low.
- R7: Opcode 7 (ALL_RST) is critical. When armed, it drives every bit of link_rst_o high in the same single next cycle.
- R8: A critical command that executes clears armed_o in the same cycle in which its effect appears.
- R9: A refused request has no effect on any level or pulse output. A request is refused when it is critical and arrives while the block is disarmed, or when it is LINK_RST with arg >= NUM_LINKS. In the next cycle reject_o is high for one cycle and reject_ch_o holds the channel index. An out-of-range LINK_RST leaves the arm state as it is.
- R10: Opcode 0 (NOP) is consumed and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_CH | Per-channel command valid |
| req_ready_o | output | NUM_CH | Per-channel command accept |
| req_op_i | input | 3*NUM_CH | Opcode of channel i at bits [3i+2:3i] |
| req_arg_i | input | ARG_W*NUM_CH | Argument of channel i at bits [ARG_W*i +: ARG_W] |
| cpu_rst_o | output | 1 | CPU reset level |
| flag_o | output | NUM_FLAGS | User flag levels |
| link_rst_o | output | NUM_LINKS | One-cycle link reset pulses |
| armed_o | output | 1 | High while a critical command would be allowed |
| reject_o | output | 1 | One-cycle pulse for a refused request |
| reject_ch_o | output | CH_W | Channel index of the refused request |

## Verification
The assertions assume that requesters follow the valid/ready rule: the opcode and argument are held while valid waits for ready. They also assume that reset is applied before the first command. Given those assumptions, the assertions expect a reset pulse only in the cycle right after an armed state, and they expect two link pulses never to appear back to back. The bench drives every request from a negative clock edge, holds it through exactly one accepting edge, and then drops it. It sweeps every opcode against every argument and both arm states, on rotating channels, plus every valid pattern for priority.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

  typedef enum logic [2:0] {
    OP_NOP         = 3'd0,
    OP_ARM         = 3'd1,
    OP_CPU_HOLD    = 3'd2,
    OP_CPU_RELEASE = 3'd3,
    OP_FLAG_SET    = 3'd4,
    OP_FLAG_CLR    = 3'd5,
    OP_LINK_RST    = 3'd6,
    OP_ALL_RST     = 3'd7
  } cmd_op_e;

  localparam int unsigned OP_W = 3;

  function automatic logic op_is_critical(input cmd_op_e op);
    return (op == OP_CPU_HOLD) || (op == OP_LINK_RST) || (op == OP_ALL_RST);
  endfunction

endpackage

// File: rtl/cmdx_prio_arb.sv
module cmdx_prio_arb #(
  parameter int unsigned N    = 3,
  parameter int unsigned IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    gnt_o,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);

  for (genvar g = 0; g < N; g++) begin : g_gnt
    if (g == 0) begin : g_first
      assign gnt_o[g] = req_i[g];
    end else begin : g_rest
      assign gnt_o[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i);
    end
  end

  // R2: a grant only ever goes to a requester, and to at most one
  always_comb begin
    a_r2_single_grant : assert ($onehot0(gnt_o));
    a_r2_grant_needs_req : assert ((gnt_o & ~req_i) == '0);
  end

endmodule

// File: rtl/cmdx_arm_guard.sv
module cmdx_arm_guard
  import cmdx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    fire_i,
  input  cmd_op_e op_i,
  input  logic    link_ok_i,
  output logic    armed_o,
  output logic    exec_o,
  output logic    refuse_o
);

  logic armed_q;
  logic crit;
  logic bad_arg;

  assign crit     = op_is_critical(op_i);
  assign bad_arg  = (op_i == OP_LINK_RST) && !link_ok_i;
  assign refuse_o = fire_i && ((crit && !armed_q) || bad_arg);
  assign exec_o   = fire_i && !refuse_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (exec_o && op_i == OP_ARM) begin
      armed_q <= 1'b1;
    end else if (exec_o && crit) begin
      armed_q <= 1'b0;
    end
  end

  assign armed_o = armed_q;

  // R8: a critical command that ran leaves the block disarmed
  a_r8_disarm_after_use : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && crit && !refuse_o) |=> !armed_q);

  // R3: an arm request always arms
  a_r3_arm_sets : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == OP_ARM) |=> armed_q);

  // R9: a refusal never changes the arm state
  a_r9_refuse_keeps_arm : assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_o |=> (armed_q == $past(armed_q)));

endmodule

// File: rtl/cmdx_action.sv
module cmdx_action
  import cmdx_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 4,
  parameter int unsigned NUM_LINKS = 3,
  parameter int unsigned ARG_W     = 2,
  parameter int unsigned CH_W      = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 exec_i,
  input  logic                 refuse_i,
  input  cmd_op_e              op_i,
  input  logic [ARG_W-1:0]     arg_i,
  input  logic [CH_W-1:0]      ch_i,
  output logic                 cpu_rst_o,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic [NUM_LINKS-1:0] link_rst_o,
  output logic                 reject_o,
  output logic [CH_W-1:0]      reject_ch_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rst_o <= 1'b0;
    end else if (exec_i && op_i == OP_CPU_HOLD) begin
      cpu_rst_o <= 1'b1;
    end else if (exec_i && op_i == OP_CPU_RELEASE) begin
      cpu_rst_o <= 1'b0;
    end
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    logic hit;
    assign hit = exec_i && (arg_i == ARG_W'(f));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[f] <= 1'b0;
      end else if (hit && op_i == OP_FLAG_SET) begin
        flag_o[f] <= 1'b1;
      end else if (hit && op_i == OP_FLAG_CLR) begin
        flag_o[f] <= 1'b0;
      end
    end
  end

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    logic one;
    assign one = (op_i == OP_LINK_RST) && (arg_i == ARG_W'(l));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        link_rst_o[l] <= 1'b0;
      end else begin
        link_rst_o[l] <= exec_i && (one || op_i == OP_ALL_RST);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reject_o    <= 1'b0;
      reject_ch_o <= '0;
    end else begin
      reject_o <= refuse_i;
      if (refuse_i) reject_ch_o <= ch_i;
    end
  end

  // R9: a refusal leaves the CPU reset and the flags untouched
  a_r9_refuse_no_level_change : assert property (@(posedge clk_i) disable iff (!rst_ni)
    refuse_i |=> ($stable(cpu_rst_o) && $stable(flag_o) && link_rst_o == '0));

endmodule

// File: rtl/ctl_cmd_exec.sv
module ctl_cmd_exec
  import cmdx_pkg::*;
#(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned NUM_FLAGS = 4,
  parameter int unsigned NUM_LINKS = 3,
  parameter int unsigned ARG_W     = 2,
  parameter int unsigned CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH-1:0]         req_valid_i,
  output logic [NUM_CH-1:0]         req_ready_o,
  input  logic [NUM_CH*OP_W-1:0]    req_op_i,
  input  logic [NUM_CH*ARG_W-1:0]   req_arg_i,
  output logic                      cpu_rst_o,
  output logic [NUM_FLAGS-1:0]      flag_o,
  output logic [NUM_LINKS-1:0]      link_rst_o,
  output logic                      armed_o,
  output logic                      reject_o,
  output logic [CH_W-1:0]           reject_ch_o
);

  localparam logic [ARG_W:0] LINK_LIM = (ARG_W + 1)'(NUM_LINKS);

  logic [NUM_CH-1:0] gnt;
  logic              any_req;
  logic [CH_W-1:0]   sel_ch;
  logic [OP_W-1:0]   sel_op_raw;
  logic [ARG_W-1:0]  sel_arg;
  cmd_op_e           sel_op;
  logic              link_ok;
  logic              exec;
  logic              refuse;

  cmdx_prio_arb #(.N(NUM_CH), .IDXW(CH_W)) i_arb (
    .req_i (req_valid_i),
    .gnt_o (gnt),
    .any_o (any_req),
    .idx_o (sel_ch)
  );

  assign req_ready_o = gnt;

  always_comb begin
    sel_op_raw = '0;
    sel_arg    = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (gnt[i]) begin
        sel_op_raw = req_op_i[i*OP_W +: OP_W];
        sel_arg    = req_arg_i[i*ARG_W +: ARG_W];
      end
    end
  end

  assign sel_op  = cmd_op_e'(sel_op_raw);
  assign link_ok = {1'b0, sel_arg} < LINK_LIM;

  cmdx_arm_guard i_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (any_req),
    .op_i      (sel_op),
    .link_ok_i (link_ok),
    .armed_o   (armed_o),
    .exec_o    (exec),
    .refuse_o  (refuse)
  );

  cmdx_action #(
    .NUM_FLAGS (NUM_FLAGS),
    .NUM_LINKS (NUM_LINKS),
    .ARG_W     (ARG_W),
    .CH_W      (CH_W)
  ) i_action (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_i      (exec),
    .refuse_i    (refuse),
    .op_i        (sel_op),
    .arg_i       (sel_arg),
    .ch_i        (sel_ch),
    .cpu_rst_o   (cpu_rst_o),
    .flag_o      (flag_o),
    .link_rst_o  (link_rst_o),
    .reject_o    (reject_o),
    .reject_ch_o (reject_ch_o)
  );

  // R4: CPU reset only rises out of an armed state, which it consumes
  a_r4_hold_needs_arm : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> ($past(armed_o) && !armed_o));

  // R6: any link pulse comes from an armed state and leaves it disarmed
  a_r6_pulse_needs_arm : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|link_rst_o) |-> ($past(armed_o) && !armed_o));

  // R6: link pulses never last two cycles
  a_r6_single_cycle_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|link_rst_o) |=> (link_rst_o == '0));

  // R9: a reject pulse and a link pulse never coincide
  a_r9_reject_no_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (link_rst_o == '0));

endmodule

// File: tb/test_ctl_cmd_exec.sv
module test_ctl_cmd_exec;

  localparam int NCH = 3;
  localparam int NFL = 4;
  localparam int NLK = 3;
  localparam int AW  = 2;
  localparam int CW  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  valid = '0;
  logic [NCH-1:0]  ready;
  logic [NCH*3-1:0]  ops = '0;
  logic [NCH*AW-1:0] args = '0;
  logic            cpu_rst;
  logic [NFL-1:0]  flags;
  logic [NLK-1:0]  link_rst;
  logic            armed;
  logic            reject;
  logic [CW-1:0]   reject_ch;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic            e_cpu = 1'b0;
  logic [NFL-1:0]  e_flags = '0;
  logic            e_armed = 1'b0;

  always #2 clk = ~clk;

  ctl_cmd_exec #(.NUM_CH(NCH), .NUM_FLAGS(NFL), .NUM_LINKS(NLK), .ARG_W(AW)) i_ctl_cmd_exec (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_op_i(ops), .req_arg_i(args), .cpu_rst_o(cpu_rst), .flag_o(flags),
    .link_rst_o(link_rst), .armed_o(armed), .reject_o(reject), .reject_ch_o(reject_ch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int ch, input int op, input int arg);
    logic crit, refuse;
    logic [NLK-1:0] e_link;
    @(negedge clk);
    valid = '0;
    valid[ch] = 1'b1;
    ops[ch*3 +: 3] = 3'(op);
    args[ch*AW +: AW] = AW'(arg);
    #1;
    chk("R2 ready to sole requester", 32'(ready), 32'(1 << ch));
    crit = (op == 2) || (op == 6) || (op == 7);
    refuse = (crit && !e_armed) || (op == 6 && arg >= NLK);
    e_link = '0;
    if (!refuse) begin
      case (op)
        1: e_armed = 1'b1;
        2: e_cpu = 1'b1;
        3: e_cpu = 1'b0;
        4: e_flags[arg] = 1'b1;
        5: e_flags[arg] = 1'b0;
        6: e_link[arg] = 1'b1;
        7: e_link = '1;
        default: ;
      endcase
      if (crit) e_armed = 1'b0;
    end
    @(negedge clk);
    valid = '0;
    chk("R4 cpu reset level", 32'(cpu_rst), 32'(e_cpu));
    chk("R5 flag levels", 32'(flags), 32'(e_flags));
    chk("R6 R7 link pulses", 32'(link_rst), 32'(e_link));
    chk("R3 R8 arm state", 32'(armed), 32'(e_armed));
    chk("R9 reject pulse", 32'(reject), 32'(refuse));
    if (refuse) chk("R9 reject channel", 32'(reject_ch), 32'(ch));
    @(negedge clk);
    chk("R6 pulse lasts one cycle", 32'(link_rst), 32'd0);
    chk("R9 reject lasts one cycle", 32'(reject), 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cpu", 32'(cpu_rst), 32'd0);
    chk("R1 reset flags", 32'(flags), 32'd0);
    chk("R1 reset links", 32'(link_rst), 32'd0);
    chk("R1 reset armed", 32'(armed), 32'd0);
    chk("R1 reset reject", 32'(reject), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release armed", 32'(armed), 32'd0);

    // R2 R10: every valid pattern, NOP commands, priority to lowest index
    for (int pat = 1; pat < (1 << NCH); pat++) begin
      @(negedge clk);
      ops = '0;
      valid = NCH'(pat);
      #1;
      chk("R2 priority grant", 32'(ready), 32'(pat & (~pat + 1)));
    end
    @(negedge clk);
    valid = '0;
    chk("R10 nop no effect cpu", 32'(cpu_rst), 32'd0);
    chk("R10 nop no effect flags", 32'(flags), 32'd0);
    chk("R10 nop no effect armed", 32'(armed), 32'd0);

    // R3..R10: each opcode against each argument and both arm states
    for (int arm = 0; arm < 2; arm++) begin
      for (int op = 0; op < 8; op++) begin
        for (int arg = 0; arg < (1 << AW); arg++) begin
          if (arm == 1) issue(0, 1, 0);
          else if (e_armed) issue(0, 7, 0);
          issue((op + arg) % NCH, op, arg);
        end
      end
    end

    // R3: arm survives a run of non-critical commands, then one use clears it
    issue(2, 1, 0);
    issue(1, 4, 2);
    issue(0, 3, 0);
    issue(2, 5, 2);
    chk("R3 arm kept over non-critical", 32'(armed), 32'd1);
    issue(1, 6, 1);
    issue(1, 6, 2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule